// File: doc/BRIEF.md
# Memory protection permission checker

This block decides, for every bus access, whether the requester may perform it. An access is an address, a kind (data read, data write or instruction fetch), a privilege flag (supervisor or user) and a source flag (CPU or DMA). A small set of address-range channels each grants its own permissions over an inclusive address window. A default permission word covers every address that no enabled channel matches. The allow decision is combinational from the access inputs. A sticky violation flag is set on the clock edge after a denied access.

Configuration and read-back use a flat address/data/write-enable port. Address 0 is the control word. It holds the six default permission bits, the CPU and DMA checking enables, and the violation flag. Each channel then occupies three consecutive addresses: base, limit and attribute. Checking is switched on per source. At reset checking is off and every default permission is granted, so the block lets everything through until software arms it.

Top module: `mpu_perm_check`

## Requirements
- R1: After reset the control word (address 0) reads 0x0000FC00. All six default permission bits are 1, both checking enables are 0 and the violation flag is 0. Every channel reads back base 0, limit 0 and attribute 0, so every channel is disabled.
- R2: A permission field is six bits. Bit 5 is supervisor read, bit 4 supervisor write, bit 3 supervisor fetch, bit 2 user read, bit 1 user write and bit 0 user fetch. In the control word this field sits at bits 15:10. Access kind codes are 0 read, 1 write and 2 fetch. Kind 3 is always denied while checking is on.
- R3: A permission bit of 1 allows the access and 0 denies it. The supervisor bits apply when `acc_super` is 1 and the user bits apply when it is 0.
- R4: Control bit 9 enables checking of CPU accesses (`acc_dma`=0). Control bit 8 enables checking of DMA accesses (`acc_dma`=1). When the enable for the access's source is 0, the access is allowed whatever the permissions.
- R5: Channel i matches when its enable is 1 and base <= address <= limit, both bounds inclusive. The channel's attribute register holds its permission field at bits 15:10 and its enable at bit 0.
- R6: When several channels match, the lowest-numbered one decides.
- R7: The default permission field decides only when no enabled channel matches. A disabled channel has no effect, even when its range covers the address.
- R8: `acc_allow` follows the access inputs in the same cycle. `viol_flag` goes to 1 on the clock edge after a cycle with `acc_valid`=1 and `acc_allow`=0, and then holds. Writing the control word with bit 0 set clears it. A new violation in the same cycle wins over the clear. An access with `acc_valid`=0 never sets the flag.
- R9: The register map is: address 0 the control word, address 1+3i the base of channel i, address 2+3i its limit, and address 3+3i its attribute. Unmapped addresses read 0. A write is seen by the access check and by read-back from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | RAW (4) | Configuration register address |
| cfg_wdata | input | DW (32) | Configuration write data |
| cfg_rdata | output | DW (32) | Read-back of the addressed register |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | AW (32) | Access address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_super | input | 1 | 1 supervisor, 0 user |
| acc_dma | input | 1 | 1 DMA source, 0 CPU source |
| acc_allow | output | 1 | Access permitted |
| viol_flag | output | 1 | Sticky violation flag |

## Verification
The assertions assume that the access inputs are stable over each cycle and that `acc_kind` may take any of its four codes. The bench changes inputs only at falling edges and sends kind 3 on purpose. The flag assertions also assume that only a control-word write with bit 0 set can clear the flag. The bench therefore keeps bit 0 at 0 in every control write that is not meant as a clear. It aims one write at the same cycle as a denied access, so that the set-over-clear ordering is exercised.

// File: rtl/mpu_perm_check.sv
module mpu_perm_check #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [$clog2(1+3*NCH)-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              acc_valid,
  input  logic [AW-1:0]     acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic              acc_super,
  input  logic              acc_dma,
  output logic              acc_allow,
  output logic              viol_flag
);
  localparam int NREG = 1 + 3*NCH;
  localparam int RAW  = $clog2(NREG);
  localparam logic [1:0] KIND_RD = 2'd0;
  localparam logic [1:0] KIND_WR = 2'd1;
  localparam logic [1:0] KIND_EX = 2'd2;

  logic [5:0]    dperm;
  logic          en_cpu, en_dma;
  logic [AW-1:0] ch_base [NCH];
  logic [AW-1:0] ch_lim  [NCH];
  logic [5:0]    ch_perm [NCH];
  logic [NCH-1:0] ch_en;
  logic [NCH-1:0] hit;
  logic [5:0]    sel_perm;
  logic          check_on, perm_ok, ctrl_wr, clr_req;

  assign ctrl_wr = cfg_we && (cfg_addr == '0);
  assign clr_req = ctrl_wr && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dperm  <= 6'h3F;
      en_cpu <= 1'b0;
      en_dma <= 1'b0;
    end else if (ctrl_wr) begin
      dperm  <= cfg_wdata[15:10];
      en_cpu <= cfg_wdata[9];
      en_dma <= cfg_wdata[8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        ch_base[i] <= '0;
        ch_lim[i]  <= '0;
        ch_perm[i] <= '0;
        ch_en[i]   <= 1'b0;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < NCH; i++) begin
        if (cfg_addr == RAW'(1 + 3*i)) ch_base[i] <= cfg_wdata[AW-1:0];
        if (cfg_addr == RAW'(2 + 3*i)) ch_lim[i]  <= cfg_wdata[AW-1:0];
        if (cfg_addr == RAW'(3 + 3*i)) begin
          ch_perm[i] <= cfg_wdata[15:10];
          ch_en[i]   <= cfg_wdata[0];
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_match
      assign hit[g] = ch_en[g] && (acc_addr >= ch_base[g]) && (acc_addr <= ch_lim[g]);
    end
  endgenerate

  always_comb begin
    sel_perm = dperm;
    for (int i = NCH-1; i >= 0; i--)
      if (hit[i]) sel_perm = ch_perm[i];
  end

  always_comb begin
    case (acc_kind)
      KIND_RD: perm_ok = acc_super ? sel_perm[5] : sel_perm[2];
      KIND_WR: perm_ok = acc_super ? sel_perm[4] : sel_perm[1];
      KIND_EX: perm_ok = acc_super ? sel_perm[3] : sel_perm[0];
      default: perm_ok = 1'b0;
    endcase
  end

  assign check_on  = acc_dma ? en_dma : en_cpu;
  assign acc_allow = !check_on || perm_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        viol_flag <= 1'b0;
    else if (acc_valid && !acc_allow)  viol_flag <= 1'b1;
    else if (clr_req)                  viol_flag <= 1'b0;
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == '0)
      cfg_rdata[15:0] = {dperm, en_cpu, en_dma, 7'b0, viol_flag};
    for (int i = 0; i < NCH; i++) begin
      if (cfg_addr == RAW'(1 + 3*i)) cfg_rdata[AW-1:0] = ch_base[i];
      if (cfg_addr == RAW'(2 + 3*i)) cfg_rdata[AW-1:0] = ch_lim[i];
      if (cfg_addr == RAW'(3 + 3*i)) cfg_rdata[15:0]   = {ch_perm[i], 9'b0, ch_en[i]};
    end
  end

  // R8
  viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_allow) |=> viol_flag);
  // R8
  viol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !clr_req) |=> viol_flag);
  // R8
  viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_flag) |-> $past(acc_valid && !acc_allow));
  // R4
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_dma ? !en_dma : !en_cpu) |-> acc_allow);
  // R2
  bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'd3 && check_on) |-> !acc_allow);
  // R9
  ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable({dperm, en_cpu, en_dma}));
endmodule

// File: tb/sim_mpu_perm_check.sv
module sim_mpu_perm_check;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cfg_we, acc_valid, acc_super, acc_dma, acc_allow, viol_flag;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata, acc_addr;
  logic [1:0]  acc_kind;

  mpu_perm_check u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_super(acc_super),
    .acc_dma(acc_dma), .acc_allow(acc_allow), .viol_flag(viol_flag)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  bit [5:0]  m_dp;
  bit        m_ec, m_ed, m_v;
  bit [31:0] m_base [NCH];
  bit [31:0] m_lim  [NCH];
  bit [5:0]  m_perm [NCH];
  bit        m_en   [NCH];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit m_allow(logic [31:0] a, int k, bit s, bit d);
    bit [5:0] p;
    bit found;
    if (!(d ? m_ed : m_ec)) return 1'b1;
    p = m_dp;
    found = 0;
    for (int i = 0; i < NCH; i++)
      if (!found && m_en[i] && a >= m_base[i] && a <= m_lim[i]) begin
        p = m_perm[i];
        found = 1;
      end
    if (k == 3) return 1'b0;
    return s ? p[5-k] : p[2-k];
  endfunction

  function automatic logic [31:0] m_rd(int a);
    if (a == 0) return {16'b0, m_dp, m_ec, m_ed, 7'b0, m_v};
    if (a <= 3*NCH) begin
      case ((a-1) % 3)
        0: return m_base[(a-1)/3];
        1: return m_lim[(a-1)/3];
        default: return {16'b0, m_perm[(a-1)/3], 9'b0, m_en[(a-1)/3]};
      endcase
    end
    return 32'h0;
  endfunction

  function automatic logic [31:0] ctrl(bit [5:0] dp, bit ec, bit ed, bit clr);
    return {16'b0, dp, ec, ed, 7'b0, clr};
  endfunction

  function automatic logic [31:0] attr(bit [5:0] p, bit en);
    return {16'b0, p, 9'b0, en};
  endfunction

  task automatic cyc(string tag, bit we, int ra, logic [31:0] wd,
                     bit v, logic [31:0] a, int k, bit s, bit d);
    bit al;
    cfg_we = we; cfg_addr = ra[3:0]; cfg_wdata = wd;
    acc_valid = v; acc_addr = a; acc_kind = k[1:0]; acc_super = s; acc_dma = d;
    #1;
    al = m_allow(a, k, s, d);
    chk({tag, " allow"}, 32'(acc_allow), 32'(al));
    chk({tag, " rdata"}, cfg_rdata, m_rd(ra));
    chk({tag, " viol"}, 32'(viol_flag), 32'(m_v));
    @(posedge clk);
    if (v && !al) m_v = 1;
    else if (we && ra == 0 && wd[0]) m_v = 0;
    if (we) begin
      if (ra == 0) {m_dp, m_ec, m_ed} = wd[15:8];
      else if (ra <= 3*NCH) begin
        case ((ra-1) % 3)
          0: m_base[(ra-1)/3] = wd;
          1: m_lim[(ra-1)/3] = wd;
          default: begin m_perm[(ra-1)/3] = wd[15:10]; m_en[(ra-1)/3] = wd[0]; end
        endcase
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(string tag, int ra, logic [31:0] wd);
    cyc(tag, 1, ra, wd, 0, 32'h0, 0, 0, 0);
  endtask

  task automatic rd(string tag, int ra);
    cyc(tag, 0, ra, 32'h0, 0, 32'h0, 0, 0, 0);
  endtask

  task automatic acc(string tag, logic [31:0] a, int k, bit s, bit d);
    cyc(tag, 0, 0, 32'h0, 1, a, k, s, d);
  endtask

  task automatic probe(string tag, logic [31:0] a);
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 3; k++)
        acc(tag, a, k, s[0], 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_dp = 6'h3F; m_ec = 0; m_ed = 0; m_v = 0;
    for (int i = 0; i < NCH; i++) begin
      m_base[i] = 0; m_lim[i] = 0; m_perm[i] = 0; m_en[i] = 0;
    end
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; acc_valid = 0;
    acc_addr = 0; acc_kind = 0; acc_super = 0; acc_dma = 0;
    repeat (3) @(negedge clk);
    #1 chk("R1 reset ctrl", cfg_rdata, 32'h0000FC00);
    chk("R1 reset viol", 32'(viol_flag), 32'h0);
    cfg_addr = 4'd3;
    #1 chk("R1 reset chan0 attr", cfg_rdata, 32'h0);
    cfg_addr = 4'd0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int a = 0; a < 16; a++) rd("R1 R9 readback after reset", a);
    probe("R1 all allowed at reset", 32'h1234);

    wr("R4 ctrl all perms off, checking off", 0, ctrl(6'h00, 0, 0, 0));
    probe("R4 cpu unchecked", 32'h40);
    acc("R4 dma unchecked", 32'h40, 1, 1, 1);
    acc("R4 kind3 unchecked", 32'h40, 3, 0, 0);

    for (int b = 0; b < 6; b++) begin
      wr("R2 single default bit", 0, ctrl(6'(1 << b), 1, 0, 1));
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 4; k++)
          acc("R2 R3 default bit decode", 32'h500, k, s[0], 0);
      acc("R4 dma still unchecked", 32'h500, 3, 0, 1);
    end

    wr("R8 clear flag", 0, ctrl(6'h3F, 1, 0, 1));
    rd("R8 flag cleared", 0);
    cyc("R8 invalid denied access ignored", 0, 0, 32'h0, 0, 32'h10, 3, 1, 0);
    rd("R8 flag still clear", 0);
    acc("R8 denied sets flag", 32'h10, 3, 0, 0);
    acc("R8 allowed keeps flag", 32'h10, 0, 0, 0);
    rd("R8 flag sticky", 0);
    cyc("R8 set wins over clear", 1, 0, ctrl(6'h3F, 1, 0, 1), 1, 32'h10, 3, 0, 0);
    rd("R8 flag after set-vs-clear", 0);
    wr("R8 clear again", 0, ctrl(6'h3F, 1, 0, 1));

    wr("R4 dma checked only", 0, ctrl(6'h00, 0, 1, 0));
    acc("R4 dma denied", 32'h20, 0, 1, 1);
    acc("R4 cpu allowed", 32'h20, 0, 1, 0);
    wr("R8 clear", 0, ctrl(6'h00, 0, 1, 1));

    wr("R5 default perms", 0, ctrl(6'b101010, 1, 0, 0));
    wr("R5 ch0 base", 1, 32'h1800); wr("R5 ch0 lim", 2, 32'h27FF);
    wr("R5 ch0 attr", 3, attr(6'h00, 1));
    wr("R6 ch1 base", 4, 32'h1000); wr("R6 ch1 lim", 5, 32'h1FFF);
    wr("R6 ch1 attr", 6, attr(6'h3F, 1));
    wr("R7 ch2 base", 7, 32'h8000); wr("R7 ch2 lim", 8, 32'h8000);
    wr("R7 ch2 attr disabled", 9, attr(6'b010101, 0));
    wr("R5 ch3 base", 10, 32'h9000); wr("R5 ch3 lim", 11, 32'h9FFF);
    wr("R5 ch3 attr", 12, attr(6'b110011, 1));
    for (int a = 0; a < 16; a++) rd("R9 map readback", a);

    probe("R7 below all channels", 32'h0FFF);
    probe("R5 ch1 lower bound", 32'h1000);
    probe("R5 ch1 only", 32'h17FF);
    probe("R6 overlap lowest wins", 32'h1800);
    probe("R6 overlap top", 32'h1FFF);
    probe("R5 ch0 only", 32'h2000);
    probe("R5 ch0 upper bound", 32'h27FF);
    probe("R7 above ch0", 32'h2800);
    probe("R7 disabled ch2 ignored", 32'h8000);
    probe("R5 ch3 inside", 32'h9ABC);
    probe("R5 ch3 upper", 32'h9FFF);
    probe("R7 past ch3", 32'hA000);

    wr("R9 enable ch2 next cycle", 9, attr(6'b010101, 1));
    probe("R5 single-address below", 32'h7FFF);
    probe("R5 single-address hit", 32'h8000);
    probe("R5 single-address above", 32'h8001);
    wr("R7 disable ch0", 3, attr(6'h00, 0));
    probe("R7 ch1 takes over", 32'h1800);
    probe("R7 default after disable", 32'h2000);

    for (int i = 0; i < 300; i++) begin
      if (i % 37 == 0) wr("R8 periodic clear", 0, ctrl(6'(i), 1, i[0], 1));
      acc("R6 R7 sweep", 32'((i * 2731) % 32'hB000), i % 4, i[1], i[2]);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule